// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block belongs to an external bus controller. When one external access finishes, it decides how many idle bus cycles must pass before the next access may start. It then holds the bus for that many clock cycles and releases the next access with a one-cycle go pulse.

The decision uses both accesses of the pair:
- the kind of each access: processor read, processor write, single-address DMA read (memory to device) or single-address DMA write (device to memory);
- the memory area number of each access;
- whether the area uses a multiplexed address/data interface;
- a flag that says the DMA target device has changed.

Dual-address DMA transfers are presented on the kind inputs as processor accesses and are handled the same way.

A small configuration register holds one 3-bit idle code for each of areas 0 to 6 and one 3-bit code for DMA. Each code sits in its own byte and is loaded through a simple write port. Reset loads every code with its largest value.

Top module: `idle_gap_inserter`

## Requirements
- R1: When `cfg_we` is high, byte index `cfg_addr` takes `cfg_wdata[2:0]`. Indices 0 to 6 select the code of that area and index 7 selects the DMA code. Bits 7:3 of the data are ignored. A write is used by any `acc_done` in a later cycle.
- R2: After the synchronous active-high reset, `bus_hold` and `next_go` are low and every code holds 7, so any inserted gap lasts 15 cycles.
- R3: A code c gives c idle cycles for c = 0 to 3, and 3*(c-2) cycles for c = 4 to 7 (6, 9, 12, 15).
- R4: The kind field encodes bit 0 = write and bit 1 = DMA, so 0 = processor read, 1 = processor write, 2 = DMA read, 3 = DMA write. If the previous kind is 3, the DMA code is used. Otherwise the code of the previous access's area is used, including when the next access is in another area.
- R5: When the previous and next areas differ, a gap is always inserted.
- R6: In the same area, a read of either initiator followed by a write of either initiator gets a gap. A read followed by a read gets none.
- R7: In the same area, a write with `prev_mpx` high gets a gap before the next access. A non-multiplexed write followed by anything other than the R8 case gets none.
- R8: In the same area, a DMA write followed by a DMA write gets a gap only when `dev_switch` is high.
- R9: When a gap applies, `next_mpx` is high and the mapped count is 0, exactly one idle cycle is inserted.
- R10: If `acc_done` is sampled at clock edge T with a count of N, then `bus_hold` is high for the N cycles after T, and `next_go` is high for the single cycle after edge T+N. With N = 0, `next_go` follows edge T directly and `bus_hold` stays low.
- R11: An `acc_done` sampled while `bus_hold` is high is ignored and does not change the running gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_addr | input | 3 | Byte index: 0 to 6 area codes, 7 DMA code |
| cfg_wdata | input | 8 | Write data; the low 3 bits are kept |
| acc_done | input | 1 | The previous access ends this cycle |
| prev_kind | input | 2 | Kind of the previous access |
| prev_area | input | 3 | Area of the previous access |
| prev_mpx | input | 1 | Previous area uses a multiplexed interface |
| next_kind | input | 2 | Kind of the next access |
| next_area | input | 3 | Area of the next access |
| next_mpx | input | 1 | Next area uses a multiplexed interface |
| dev_switch | input | 1 | DMA target device changes between the two accesses |
| bus_hold | output | 1 | Idle cycles are being counted down |
| next_go | output | 1 | One-cycle release of the next access |

## Verification
The bench builds the block with its default parameters: seven areas, a 3-bit area number and a 4-bit counter. With these values all eight code values, the full 15-cycle gap after reset and both field sources (area code and DMA code) can be reached. A behavioural model predicts `bus_hold` and `next_go` in every cycle. Directed gap-length measurements cover each rule of the pair decision, the one-cycle minimum on multiplexed areas, and an end signal that arrives while a gap is already running.

// File: rtl/idl_pkg.sv
package idl_pkg;

    localparam int IDL_FIELD_W = 3;
    localparam int IDL_CNT_W   = 4;

    typedef enum logic [1:0] {
        KIND_CPU_RD = 2'd0,
        KIND_CPU_WR = 2'd1,
        KIND_DMA_RD = 2'd2,
        KIND_DMA_WR = 2'd3
    } acc_kind_e;

    // Expand a 3-bit idle code into a cycle count: linear up to 3, then steps of 3.
    function automatic logic [IDL_CNT_W-1:0] idle_cycles(input logic [IDL_FIELD_W-1:0] code);
        if (code <= IDL_FIELD_W'(3))
            return IDL_CNT_W'(code);
        else
            return IDL_CNT_W'(3 * (int'(code) - 2));
    endfunction

    function automatic logic is_write(input acc_kind_e k);
        return k[0];
    endfunction

endpackage

// File: rtl/idl_cfg_regs.sv
module idl_cfg_regs
    import idl_pkg::*;
#(
    parameter int NUM_AREAS = 7,
    parameter int ADDR_W    = $clog2(NUM_AREAS + 1)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   cfg_we,
    input  logic [ADDR_W-1:0]                      cfg_addr,
    input  logic [7:0]                             cfg_wdata,
    output logic [NUM_AREAS-1:0][IDL_FIELD_W-1:0]  area_code,
    output logic [IDL_FIELD_W-1:0]                 dma_code
);

    typedef struct packed {
        logic [NUM_AREAS-1:0][IDL_FIELD_W-1:0] area;
        logic [IDL_FIELD_W-1:0]                dma;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int i = 0; i < NUM_AREAS; i++) begin
                if (cfg_addr == ADDR_W'(i))
                    cfg_d.area[i] = cfg_wdata[IDL_FIELD_W-1:0];
            end
            if (cfg_addr == ADDR_W'(NUM_AREAS))
                cfg_d.dma = cfg_wdata[IDL_FIELD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '1;
        else
            cfg_q <= cfg_d;
    end

    assign area_code = cfg_q.area;
    assign dma_code  = cfg_q.dma;

endmodule

// File: rtl/idl_gap_select.sv
module idl_gap_select
    import idl_pkg::*;
#(
    parameter int NUM_AREAS = 7,
    parameter int AREA_W    = 3
) (
    input  acc_kind_e                              prev_kind,
    input  logic [AREA_W-1:0]                      prev_area,
    input  logic                                   prev_mpx,
    input  acc_kind_e                              next_kind,
    input  logic [AREA_W-1:0]                      next_area,
    input  logic                                   next_mpx,
    input  logic                                   dev_switch,
    input  logic [NUM_AREAS-1:0][IDL_FIELD_W-1:0]  area_code,
    input  logic [IDL_FIELD_W-1:0]                 dma_code,
    output logic [IDL_CNT_W-1:0]                   gap_cycles
);

    logic [NUM_AREAS-1:0][IDL_CNT_W-1:0] area_cycles;
    logic [IDL_CNT_W-1:0]                dma_cycles;

    // One code expander per area.
    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_expand
        assign area_cycles[g] = idle_cycles(area_code[g]);
    end
    assign dma_cycles = idle_cycles(dma_code);

    typedef struct packed {
        logic                 same_area;
        logic                 insert;
        logic [AREA_W-1:0]    area_idx;
        logic [IDL_CNT_W-1:0] base;
    } sel_t;

    sel_t sel_d;

    always_comb begin
        sel_d = '0;
        sel_d.same_area = (prev_area == next_area);
        sel_d.area_idx  = (prev_area < AREA_W'(NUM_AREAS)) ? prev_area
                                                           : AREA_W'(NUM_AREAS - 1);
        if (prev_kind == KIND_DMA_WR)
            sel_d.base = dma_cycles;
        else
            sel_d.base = area_cycles[sel_d.area_idx];

        if (!sel_d.same_area)
            sel_d.insert = 1'b1;
        else if (!is_write(prev_kind) && is_write(next_kind))
            sel_d.insert = 1'b1;
        else if (is_write(prev_kind) && prev_mpx)
            sel_d.insert = 1'b1;
        else if (prev_kind == KIND_DMA_WR && next_kind == KIND_DMA_WR && dev_switch)
            sel_d.insert = 1'b1;
        else
            sel_d.insert = 1'b0;

        if (!sel_d.insert)
            gap_cycles = '0;
        else if (next_mpx && sel_d.base == '0)
            gap_cycles = IDL_CNT_W'(1);
        else
            gap_cycles = sel_d.base;
    end

endmodule

// File: rtl/idl_gap_timer.sv
module idl_gap_timer
    import idl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_done,
    input  logic [IDL_CNT_W-1:0] gap_cycles,
    output logic                 bus_hold,
    output logic                 next_go
);

    typedef struct packed {
        logic [IDL_CNT_W-1:0] remain;
        logic                 go;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        tmr_d.go = 1'b0;
        if (tmr_q.remain != '0) begin
            tmr_d.remain = tmr_q.remain - IDL_CNT_W'(1);
            tmr_d.go     = (tmr_q.remain == IDL_CNT_W'(1));
        end else if (acc_done) begin
            if (gap_cycles == '0)
                tmr_d.go = 1'b1;
            else
                tmr_d.remain = gap_cycles;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tmr_q <= '0;
        else
            tmr_q <= tmr_d;
    end

    assign bus_hold = (tmr_q.remain != '0);
    assign next_go  = tmr_q.go;

endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
    import idl_pkg::*;
#(
    parameter int NUM_AREAS = 7,
    parameter int AREA_W    = 3,
    parameter int ADDR_W    = $clog2(NUM_AREAS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              acc_done,
    input  logic [1:0]        prev_kind,
    input  logic [AREA_W-1:0] prev_area,
    input  logic              prev_mpx,
    input  logic [1:0]        next_kind,
    input  logic [AREA_W-1:0] next_area,
    input  logic              next_mpx,
    input  logic              dev_switch,
    output logic              bus_hold,
    output logic              next_go
);

    logic [NUM_AREAS-1:0][IDL_FIELD_W-1:0] area_code;
    logic [IDL_FIELD_W-1:0]                dma_code;
    logic [IDL_CNT_W-1:0]                  gap_cycles;

    idl_cfg_regs #(
        .NUM_AREAS (NUM_AREAS),
        .ADDR_W    (ADDR_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .area_code (area_code),
        .dma_code  (dma_code)
    );

    idl_gap_select #(
        .NUM_AREAS (NUM_AREAS),
        .AREA_W    (AREA_W)
    ) u_sel (
        .prev_kind  (acc_kind_e'(prev_kind)),
        .prev_area  (prev_area),
        .prev_mpx   (prev_mpx),
        .next_kind  (acc_kind_e'(next_kind)),
        .next_area  (next_area),
        .next_mpx   (next_mpx),
        .dev_switch (dev_switch),
        .area_code  (area_code),
        .dma_code   (dma_code),
        .gap_cycles (gap_cycles)
    );

    idl_gap_timer u_tmr (
        .clk        (clk),
        .rst        (rst),
        .acc_done   (acc_done),
        .gap_cycles (gap_cycles),
        .bus_hold   (bus_hold),
        .next_go    (next_go)
    );

endmodule

// File: rtl/idl_checker.sv
module idl_checker #(
    parameter int AREA_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_done,
    input logic [AREA_W-1:0] prev_area,
    input logic [AREA_W-1:0] next_area,
    input logic              next_mpx,
    input logic              bus_hold,
    input logic              next_go
);

    // R10: the end of a hold window always releases the next access
    assert_go_after_hold_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_hold) |-> next_go);

    // R10: release and hold never overlap
    assert_hold_go_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_hold && next_go));

    // R10: a release comes only from an accepted end or a finished hold
    assert_go_source_R10: assert property (@(posedge clk) disable iff (rst)
        next_go |-> ($past(bus_hold) || $past(acc_done)));

    // R11: a hold window only opens right after an accepted end
    assert_hold_start_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_hold) |-> ($past(acc_done) && !$past(bus_hold)));

    // R11: an end during a hold neither stops the hold nor skips the release
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_hold && acc_done) |=> (bus_hold || next_go));

    // R9: a multiplexed next access to another area always gets at least one idle cycle
    assert_mpx_min_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_done && !bus_hold && next_mpx && (prev_area != next_area)) |=> bus_hold);

endmodule

bind idle_gap_inserter idl_checker #(.AREA_W(AREA_W)) u_idl_checker (
    .clk       (clk),
    .rst       (rst),
    .acc_done  (acc_done),
    .prev_area (prev_area),
    .next_area (next_area),
    .next_mpx  (next_mpx),
    .bus_hold  (bus_hold),
    .next_go   (next_go)
);

// File: tb/tb_idle_gap_inserter.sv
module tb_idle_gap_inserter;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       acc_done = 1'b0;
    logic [1:0] prev_kind = '0;
    logic [2:0] prev_area = '0;
    logic       prev_mpx = 1'b0;
    logic [1:0] next_kind = '0;
    logic [2:0] next_area = '0;
    logic       next_mpx = 1'b0;
    logic       dev_switch = 1'b0;
    logic       bus_hold;
    logic       next_go;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_gap_inserter dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_done(acc_done), .prev_kind(prev_kind), .prev_area(prev_area), .prev_mpx(prev_mpx),
        .next_kind(next_kind), .next_area(next_area), .next_mpx(next_mpx),
        .dev_switch(dev_switch), .bus_hold(bus_hold), .next_go(next_go)
    );

    // ---------------- behavioural reference model ----------------
    int m_area [7];
    int m_dma;
    int m_rem;
    bit m_go;

    function automatic int model_gap(int pk, int pa, int pm, int nk, int na, int nm, int sw);
        int code, cyc;
        bit ins;
        code = (pk == 3) ? m_dma : m_area[pa];
        cyc  = (code < 4) ? code : (code - 2) * 3;
        if (pa != na)                          ins = 1;
        else if ((pk % 2 == 0) && (nk % 2 == 1)) ins = 1;
        else if ((pk % 2 == 1) && pm != 0)     ins = 1;
        else if (pk == 3 && nk == 3 && sw != 0) ins = 1;
        else                                   ins = 0;
        if (!ins) return 0;
        if (nm != 0 && cyc == 0) return 1;
        return cyc;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_area[i]) m_area[i] = 7;
            m_dma = 7;
            m_rem = 0;
            m_go  = 0;
        end else begin
            int n;
            n = model_gap(int'(prev_kind), int'(prev_area), int'(prev_mpx), int'(next_kind),
                          int'(next_area), int'(next_mpx), int'(dev_switch));
            m_go = 0;
            if (m_rem > 0) begin
                if (m_rem == 1) m_go = 1;
                m_rem = m_rem - 1;
            end else if (acc_done) begin
                if (n == 0) m_go = 1;
                else m_rem = n;
            end
            if (cfg_we) begin
                if (cfg_addr < 7) m_area[cfg_addr] = int'(cfg_wdata) % 8;
                else m_dma = int'(cfg_wdata) % 8;
            end
        end
    end

    // R10: per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (bus_hold !== (m_rem != 0) || next_go !== m_go) begin
                fails++;
                $display("FAIL R10 cycle compare: hold=%0b go=%0b expected hold=%0b go=%0b",
                         bus_hold, next_go, (m_rem != 0), m_go);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic wr_cfg(int addr, int data);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 8'(data);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_pair(int pk, int pa, int pm, int nk, int na, int nm, int sw);
        prev_kind = 2'(pk); prev_area = 3'(pa); prev_mpx = 1'(pm);
        next_kind = 2'(nk); next_area = 3'(na); next_mpx = 1'(nm);
        dev_switch = 1'(sw);
    endtask

    // Pulse acc_done once, then count hold cycles until the release.
    task automatic gap(string tag, int pk, int pa, int pm, int nk, int na, int nm, int sw,
                       int expn);
        int n;
        bit seen;
        @(posedge clk); #1;
        set_pair(pk, pa, pm, nk, na, nm, sw);
        acc_done = 1'b1;
        @(posedge clk); #1;
        acc_done = 1'b0;
        n = 0; seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (next_go) begin seen = 1; break; end
            if (bus_hold) n++;
        end
        check({tag, " release seen"}, int'(seen), 1);
        check({tag, " hold length"}, n, expn);
        @(posedge clk); #1;
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R2 reset bus_hold", int'(bus_hold), 0);
        check("R2 reset next_go", int'(next_go), 0);

        // R2/R3: default code 7 -> 15 cycles
        gap("R2 default area code", 0, 1, 0, 0, 2, 0, 0, 15);
        gap("R2 default dma code", 3, 1, 0, 0, 2, 0, 0, 15);

        // R1: program codes, upper data bits set to show they are dropped
        for (int a = 0; a < 7; a++) wr_cfg(a, 8'hF8 | a);
        wr_cfg(7, 8'hA2);

        // R3: every code through a different-area pair (R5)
        gap("R3 code0", 1, 0, 0, 0, 1, 0, 0, 0);
        gap("R3 code1", 1, 1, 0, 0, 2, 0, 0, 1);
        gap("R3 code2", 0, 2, 0, 0, 3, 0, 0, 2);
        gap("R3 code3", 0, 3, 0, 1, 4, 0, 0, 3);
        gap("R3 code4", 0, 4, 0, 0, 5, 0, 0, 6);
        gap("R3 code5", 2, 5, 0, 0, 6, 0, 0, 9);
        gap("R5 code6 different area", 0, 6, 0, 0, 0, 0, 0, 12);

        // R4: DMA write takes the DMA code, processor write takes the area code
        gap("R4 dma write uses dma code", 3, 5, 0, 0, 1, 0, 0, 2);
        gap("R4 cpu write uses area code", 1, 5, 0, 0, 1, 0, 0, 9);
        gap("R4 previous area code chosen", 0, 1, 0, 0, 6, 0, 0, 1);

        // R6: same area read/write turnarounds
        gap("R6 read then write", 0, 3, 0, 1, 3, 0, 0, 3);
        gap("R6 dma read then cpu write", 2, 3, 0, 1, 3, 0, 0, 3);
        gap("R6 read then read", 0, 3, 0, 0, 3, 0, 0, 0);
        gap("R6 read then dma write", 0, 4, 0, 3, 4, 0, 0, 6);

        // R7: same area after write
        gap("R7 mpx write then read", 1, 4, 1, 0, 4, 1, 0, 6);
        gap("R7 plain write then read", 1, 4, 0, 0, 4, 0, 0, 0);
        gap("R7 plain write then write", 1, 2, 0, 1, 2, 0, 0, 0);

        // R8: DMA write after DMA write in the same area
        gap("R8 device switch", 3, 2, 0, 3, 2, 0, 1, 2);
        gap("R8 no device switch", 3, 2, 0, 3, 2, 0, 0, 0);

        // R9: multiplexed minimum of one cycle
        gap("R9 mpx other area code0", 1, 0, 0, 0, 1, 1, 0, 1);
        gap("R9 mpx same area write code0", 1, 0, 1, 0, 0, 1, 0, 1);
        gap("R9 mpx no gap stays zero", 0, 0, 1, 0, 0, 1, 0, 0);

        // R1: rewrite the DMA code and use it in the next cycle
        wr_cfg(7, 8'h05);
        gap("R1 dma code rewrite", 3, 0, 0, 0, 1, 0, 0, 9);
        wr_cfg(0, 8'h03);
        gap("R1 area code rewrite", 0, 0, 0, 0, 1, 0, 0, 3);

        // R11: an end pulse during a running gap is ignored
        begin
            int n;
            bit seen;
            @(posedge clk); #1;
            set_pair(0, 6, 0, 0, 0, 0, 0);
            acc_done = 1'b1;
            @(posedge clk); #1;
            acc_done = 1'b0;
            repeat (3) @(posedge clk);
            #1;
            set_pair(1, 0, 0, 0, 1, 0, 0);
            acc_done = 1'b1;
            @(posedge clk); #1;
            acc_done = 1'b0;
            n = 4; seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (next_go) begin seen = 1; break; end
                if (bus_hold) n++;
            end
            check("R11 release seen", int'(seen), 1);
            check("R11 hold unchanged", n, 12);
            @(negedge clk);
            check("R11 no second gap", int'(bus_hold || next_go), 0);
        end

        // R10: zero gap releases on the first cycle after the end
        @(posedge clk); #1;
        set_pair(0, 3, 0, 0, 3, 0, 0);
        acc_done = 1'b1;
        @(posedge clk); #1;
        acc_done = 1'b0;
        @(negedge clk);
        check("R10 zero gap go", int'(next_go), 1);
        check("R10 zero gap no hold", int'(bus_hold), 0);
        @(negedge clk);
        check("R10 go single cycle", int'(next_go), 0);

        repeat (3) @(posedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule